// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Port

This block is a synthesizable model of a static RAM with a separate read port and a separate write port. Each read or write moves four words. A single fast clock `clk` runs at twice the nominal K rate. Its rising edges alternate between a "K phase" and a "K-bar phase". The first rising edge with `rstN` high is a K-phase edge. Reset is active-low and synchronous.

The address and both strobes count only on K-phase edges. Write data and byte-lane enables are taken on every edge of a write burst. Read words are launched alternately on the K-bar-aligned and K-aligned output phases. A free-running echo clock pair marks which phase is current. Both ports are independent and can carry a burst at the same time. The memory array is a small parameterised register array that clears on reset.

Top module: `qdrb4_sram`

## Requirements
- R1: While `rstN` is low, `qValid` is 0, `qData` is all zeros, `echoClk` is 0 and `echoClkN` is 1. The memory clears to zero.
- R2: After reset, `echoClk` toggles on every `clk` edge, and `echoClkN` is always its complement. `echoClk` is 0 in a cycle that follows a K-bar-phase edge and 1 in a cycle that follows a K-phase edge.
- R3: `readN`, `writeN` and `addr` are sampled only on K-phase edges. A low strobe on a K-bar-phase edge has no effect.
- R4: A read accepted on K-phase edge n fetches word k of group `addr`, at word index `addr*4+k`, on edge n+3+k, for k = 0 to 3. Each word is visible on `qData` in the cycle after that edge. The first word is therefore 3 phases (1.5 K periods) after the command. Words 0 and 2 follow K-bar edges, and words 1 and 3 follow K edges.
- R5: `qValid` is 1 exactly in the four cycles that carry burst words. In every other cycle `qValid` is 0 and `qData` is zero.
- R6: `readN` is ignored on the K-phase edge right after an accepted read. If `readN` is held low, reads are accepted on every second K edge, and the bursts follow each other with no idle cycle.
- R7: A write accepted on K-phase edge n writes beat k to word index `addr*4+k`, for k = 0 to 3. Beat k takes the `dataIn` and `byteWrN` sampled on edge n+k.
- R8: `byteWrN[b]` is active low and guards lane b, which is bits [9b+8:9b] of a word. It is applied separately on each beat. A lane with its enable high keeps its old contents.
- R9: `writeN` is ignored on the K-phase edge right after an accepted write.
- R10: Reads and writes run concurrently and do not disturb each other. A read accepted on the same edge as a write to the same group returns the newly written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the K rate; edges alternate K and K-bar phases |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (3) | Burst group address, sampled on K-phase edges |
| readN | input | 1 | Active-low read strobe |
| writeN | input | 1 | Active-low write strobe |
| byteWrN | input | LANES (2) | Active-low per-lane write enables, one per beat |
| dataIn | input | LANES*LANE_W (18) | Write data, one beat per edge |
| qData | output | LANES*LANE_W (18) | Read data; zero when not driving a burst |
| qValid | output | 1 | Output enable; high while a burst word is driven |
| echoClk | output | 1 | Free-running echo clock, high after K-phase edges |
| echoClkN | output | 1 | Complement of `echoClk` |

## Verification
The bench targets phase alignment of the strobes. A design that accepted a strobe on a K-bar edge would start a stray burst or corrupt memory.

It also targets the blocked edge after each accepted command. A wrong lockout would give doubled bursts, or would leave a gap in back-to-back reads.

The exact 3-phase read latency is measured directly. A pipeline one stage long or short shifts every word.

It checks per-beat lane masking and the hand-off of the read address while a second read is pending. An address overwritten too early would return words from the wrong group. Finally, it checks a read and a write to the same group on the same edge, which must return the new data.

// File: rtl/qdrb4_pkg.sv
package qdrb4_pkg;
  localparam int BEATS  = 4;
  localparam int RD_LAT = 3;

  typedef struct packed {
    logic       phaseK;     // next edge is a K-phase edge
    logic       rdCapture;  // latch read group address
    logic       rdHandoff;  // move latched address to fetch register
    logic       rdFetch;    // fetch one read word on this edge
    logic [1:0] rdBeat;     // word within the read group
    logic       wrEnable;   // write one beat on this edge
    logic       wrLive;     // beat 0: use live address
    logic [1:0] wrBeat;     // word within the write group
  } qdrStrobes_t;
endpackage

// File: rtl/qdrb4_ctrl.sv
module qdrb4_ctrl
  import qdrb4_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readN,
  input  logic        writeN,
  output qdrStrobes_t strb,
  output logic        echoClk,
  output logic        echoClkN
);
  localparam int RD_SPAN = RD_LAT + BEATS - 1;

  logic               phaseK;
  logic               rdBlock;
  logic               wrBlock;
  logic [RD_SPAN:1]   rdDly;
  logic [BEATS-1:1]   wrDly;
  logic               rdAccept;
  logic               wrAccept;

  assign rdAccept = phaseK & ~readN & ~rdBlock;
  assign wrAccept = phaseK & ~writeN & ~wrBlock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseK  <= 1'b1;
      rdBlock <= 1'b0;
      wrBlock <= 1'b0;
      rdDly   <= '0;
      wrDly   <= '0;
    end else begin
      phaseK <= ~phaseK;
      if (phaseK) begin
        rdBlock <= rdAccept;
        wrBlock <= wrAccept;
      end
      rdDly <= {rdDly[RD_SPAN-1:1], rdAccept};
      wrDly <= {wrDly[BEATS-2:1], wrAccept};
    end
  end

  always_comb begin
    strb           = '0;
    strb.phaseK    = phaseK;
    strb.rdCapture = rdAccept;
    strb.rdHandoff = rdDly[RD_LAT-1];
    strb.rdFetch   = |rdDly[RD_SPAN:RD_LAT];
    for (int k = 0; k < BEATS; k++)
      if (rdDly[RD_LAT+k]) strb.rdBeat = 2'(k);
    strb.wrLive    = wrAccept;
    strb.wrEnable  = wrAccept | (|wrDly);
    for (int k = 1; k < BEATS; k++)
      if (wrDly[k]) strb.wrBeat = 2'(k);
  end

  assign echoClk  = ~phaseK;
  assign echoClkN = phaseK;

  // Echo clock runs freely after reset (R2)
  assert_echo_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (echoClk != $past(echoClk)))
    else $error("echo clock stalled");

  // Read strobe locked out on the following K edge (R6)
  assert_read_lockout_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdAccept |=> ##1 !rdAccept)
    else $error("read accepted on blocked edge");

  // Write strobe locked out on the following K edge (R9)
  assert_write_lockout_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |=> ##1 !wrAccept)
    else $error("write accepted on blocked edge");

  // At most one read word fetched per edge (R6)
  assert_single_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdDly[RD_SPAN:RD_LAT]))
    else $error("overlapping read fetches");
endmodule

// File: rtl/qdrb4_dpath.sv
module qdrb4_dpath
  import qdrb4_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  qdrStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qData,
  output logic              qValid
);
  localparam int IDX_W = ADDR_W + 2;
  localparam int WORDS = BEATS << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] rdAddrHold;
  logic [ADDR_W-1:0] rdAddrFetch;
  logic [ADDR_W-1:0] wrAddrHold;
  logic [DATA_W-1:0] laneMask;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneMask[b*LANE_W +: LANE_W] = {LANE_W{~byteWrN[b]}};
  end

  assign wrIdx = strb.wrLive ? {addr, 2'b00} : {wrAddrHold, strb.wrBeat};
  assign rdIdx = {rdAddrFetch, strb.rdBeat};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdAddrHold  <= '0;
      rdAddrFetch <= '0;
      wrAddrHold  <= '0;
      qData       <= '0;
      qValid      <= 1'b0;
    end else begin
      if (strb.rdCapture) rdAddrHold  <= addr;
      if (strb.rdHandoff) rdAddrFetch <= rdAddrHold;
      if (strb.wrLive)    wrAddrHold  <= addr;
      if (strb.wrEnable)
        mem[wrIdx] <= (mem[wrIdx] & ~laneMask) | (dataIn & laneMask);
      qValid <= strb.rdFetch;
      qData  <= strb.rdFetch ? mem[rdIdx] : '0;
    end
  end

  // First burst word lands after a K-bar edge (R4)
  assert_first_word_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qValid) |-> strb.phaseK)
    else $error("burst started on wrong phase");

  // A started burst lasts four words (R5)
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qValid) |=> qValid ##1 qValid ##1 qValid)
    else $error("short read burst");

  // Idle output bus is zero (R5)
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !qValid |-> (qData == '0))
    else $error("data driven while idle");
endmodule

// File: rtl/qdrb4_sram.sv
module qdrb4_sram
  import qdrb4_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              readN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qData,
  output logic              qValid,
  output logic              echoClk,
  output logic              echoClkN
);
  qdrStrobes_t strb;

  qdrb4_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .readN    (readN),
    .writeN   (writeN),
    .strb     (strb),
    .echoClk  (echoClk),
    .echoClkN (echoClkN)
  );

  qdrb4_dpath #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .byteWrN (byteWrN),
    .dataIn  (dataIn),
    .qData   (qData),
    .qValid  (qValid)
  );
endmodule

// File: tb/qdrb4_sram_tb_top.sv
`timescale 1ns/1ps
module qdrb4_sram_tb_top;
  localparam int AW    = 3;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int WORDS = 4 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          readN = 1'b1;
  logic          writeN = 1'b1;
  logic [LN-1:0] byteWrN = '1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] qData;
  logic          qValid;
  logic          echoClk;
  logic          echoClkN;

  always #2.5 clk = ~clk;

  qdrb4_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .readN(readN), .writeN(writeN),
    .byteWrN(byteWrN), .dataIn(dataIn), .qData(qData), .qValid(qValid),
    .echoClk(echoClk), .echoClkN(echoClkN)
  );

  int    nChecks = 0;
  int    nBad = 0;
  bit    finished = 0;
  string curTag = "R5";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit            mPhaseK = 1;
  bit            mRdBlk, mWrBlk, mLive;
  int            mEdge, mWrNext, mWrGrp;
  logic [DW-1:0] mMem [WORDS];
  int            fetchW [int];
  bit            expV;
  logic [DW-1:0] expD;

  function automatic void memWrite(int idx);
    for (int b = 0; b < LN; b++)
      if (!byteWrN[b]) mMem[idx][b*LW +: LW] = dataIn[b*LW +: LW];
  endfunction

  always @(posedge clk) begin
    bit rdAcc;
    bit wrAcc;
    if (!rstN) begin
      mPhaseK = 1; mRdBlk = 0; mWrBlk = 0; mLive = 0;
      mEdge = 0; mWrNext = 4; mWrGrp = 0;
      fetchW.delete();
      for (int i = 0; i < WORDS; i++) mMem[i] = '0;
      expV = 0; expD = '0;
    end else begin
      rdAcc = mPhaseK && !readN && !mRdBlk;
      wrAcc = mPhaseK && !writeN && !mWrBlk;
      if (fetchW.exists(mEdge)) begin
        expV = 1; expD = mMem[fetchW[mEdge]]; fetchW.delete(mEdge);
      end else begin
        expV = 0; expD = '0;
      end
      if (rdAcc) for (int k = 0; k < 4; k++) fetchW[mEdge + 3 + k] = int'(addr) * 4 + k;
      if (mWrNext < 4) begin memWrite(mWrGrp * 4 + mWrNext); mWrNext++; end
      if (wrAcc) begin mWrGrp = int'(addr); memWrite(mWrGrp * 4); mWrNext = 1; end
      if (mPhaseK) begin mRdBlk = rdAcc; mWrBlk = wrAcc; end
      mPhaseK = !mPhaseK;
      mEdge++;
      mLive = 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && mLive && !finished) begin
      chk({curTag, " qValid"}, 64'(qValid), 64'(expV));
      chk({curTag, " qData"}, 64'(qData), 64'(expD));
      chk("R2 echoClk", 64'(echoClk), 64'(!mPhaseK));
      chk("R2 echoClkN", 64'(echoClkN), 64'(mPhaseK));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit r, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [LN-1:0] be);
    readN = r; writeN = w; addr = a; dataIn = d; byteWrN = be;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, '0, '0, '1);
  endtask

  task automatic toK();
    while (!mPhaseK) idle(1);
  endtask

  // beat k data = seed ^ (k * 'h1111); be holds four lane masks, beat 0 lowest
  task automatic burst(input bit doRd, input bit doWr, input logic [AW-1:0] a,
                       input logic [DW-1:0] seed, input logic [4*LN-1:0] be);
    toK();
    for (int k = 0; k < 4; k++)
      step((k == 0 && doRd) ? 1'b0 : 1'b1, (k == 0 && doWr) ? 1'b0 : 1'b1,
           a, seed ^ DW'(k * 'h1111), be[k*LN +: LN]);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 qValid", 64'(qValid), 64'h0);
    chk("R1 qData", 64'(qData), 64'h0);
    chk("R1 echoClk", 64'(echoClk), 64'h0);
    chk("R1 echoClkN", 64'(echoClkN), 64'h1);
    rstN = 1'b1;
    idle(4);

    // R7: full write to group 2, then read back
    curTag = "R7";
    burst(0, 1, 3'd2, 18'h2A5A0, '0);
    idle(2);

    // R4: exact latency of the read of group 2
    curTag = "R4";
    toK();
    step(0, 1, 3'd2, '0, '1);
    chk("R4 no data at accept", 64'(qValid), 64'h0);
    idle(2);
    chk("R4 no data after 2 phases", 64'(qValid), 64'h0);
    idle(1);
    chk("R4 first word valid at 3 phases", 64'(qValid), 64'h1);
    chk("R4 first word value", 64'(qData), 64'h2A5A0);
    chk("R4 first word after K-bar edge", 64'(echoClk), 64'h0);
    idle(1);
    chk("R4 second word value", 64'(qData), 64'(18'h2A5A0 ^ 18'h1111));
    idle(6);

    // R3: strobes and address on K-bar edges have no effect
    curTag = "R3";
    toK();
    idle(1);
    step(0, 0, 3'd5, 18'h3FFFF, '0);
    idle(1);
    idle(8);
    burst(1, 0, 3'd5, '0, '1);  // group 5 must still read zero
    idle(8);

    // R8: per-beat lane masks on group 4
    curTag = "R8";
    burst(0, 1, 3'd4, 18'h15555, '0);
    idle(2);
    burst(0, 1, 3'd4, 18'h0F0F0, {2'b00, 2'b10, 2'b01, 2'b11});
    idle(2);
    burst(1, 0, 3'd4, '0, '1);
    idle(8);

    // R6: read strobe held low gives back-to-back bursts, groups 2 then 4
    curTag = "R6";
    toK();
    for (int i = 0; i < 8; i++) step(0, 1, (i < 4) ? 3'd2 : 3'd4, '0, '1);
    idle(10);

    // R9: write strobe held low through the lockout edge
    curTag = "R9";
    toK();
    for (int i = 0; i < 4; i++) step(1, 0, (i < 2) ? 3'd6 : 3'd7, DW'(18'h01000 + i), '0);
    idle(2);
    burst(1, 0, 3'd6, '0, '1);
    idle(2);
    burst(1, 0, 3'd7, '0, '1);
    idle(8);

    // R10: read and write to the same group on the same edge
    curTag = "R10";
    burst(1, 1, 3'd3, 18'h3C3C3, '0);
    idle(8);
    burst(0, 1, 3'd1, 18'h12345, '0);
    burst(1, 1, 3'd1, 18'h0ABCD, '0);
    idle(8);

    // R10: mixed concurrent traffic
    for (int i = 0; i < 600; i++)
      step(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom), LN'($urandom));
    idle(12);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule